// File: doc/BRIEF.md
# Keyed Byte Copy Engine

This block moves a run of bytes through a single synchronous byte memory port on behalf of an 8-bit processor. A caller supplies a 16-bit source pointer, destination pointer and byte count, an 8-bit skip value, a two-bit mode and a repeat flag, then pulses `start`. Each step reads one byte. If that byte differs from the skip value, the step writes it to the destination address. If the byte equals the skip value, no write happens. This lets a sprite or tile image with a "clear" colour be laid over existing data without overwriting the background.

Three address patterns are available. The source can count upward or downward. A third mode replays an aligned row of eight source bytes, where the byte within the row is chosen by the low bits of the destination, to fill a region with a repeating pattern. The destination always counts upward and the count always counts down. With repeat off, the engine does one step. With repeat on, it keeps stepping until the count reaches zero, always doing the first step before testing. When the engine finishes, it presents the updated pointers and count and raises `done` for one cycle.

Top module: `keyed_copy_engine`

## Requirements
- R1: A byte read that equals the skip value captured at start is never written. Every other byte read is written, unchanged, to the current destination address. The copy proceeds strictly step by step, so overlapping regions see earlier writes.
- R2: Mode 0 (and mode 3, which behaves the same) reads at the source pointer. After each step the source pointer increases by one, the destination increases by one and the count decreases by one.
- R3: Mode 1 reads at the source pointer. After each step the source pointer decreases by one, the destination increases by one and the count decreases by one.
- R4: Mode 2 reads at the address formed by bits 15..3 of the source pointer and bits 2..0 of the destination pointer. The source pointer never changes, the destination increases by one and the count decreases by one.
- R5: With repeat off, exactly one step is made whatever the count. A starting count of 0 finishes with count 16'hFFFF.
- R6: With repeat on, steps continue until the count reaches zero, and at least one step is always made. A starting count of 0 makes 65536 steps and finishes with count 0.
- R7: The memory returns read data one cycle after a read request. A step whose byte is skipped takes 2 cycles and a step that writes takes 3 cycles. `done` is seen after exactly the sum of these cycles, counted from the clock edge that samples `start`. Read and write requests never occur in the same cycle.
- R8: `done` is high for exactly one cycle per operation. `busy` is high from the cycle after `start` until `done`. A `start` pulse while `busy` is high has no effect on the operation or its results.
- R9: Pointers wrap modulo 65536 in both directions without any error indication.
- R10: After reset, all outputs are zero, with `busy`, `done`, `mem_rd` and `mem_wr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| mode | input | 2 | 0/3 source up, 1 source down, 2 pattern row |
| repeat_en | input | 1 | 1: loop until count is zero; 0: one step |
| src_in | input | 16 | Starting source pointer |
| dst_in | input | 16 | Starting destination pointer |
| cnt_in | input | 16 | Starting byte count |
| key_in | input | 8 | Skip value |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read request, data returned next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current count |

## Verification
A wrong step decision, such as a skipped byte that should have been written, shows up at once in memory contents and in the cycle count of the operation. A pointer or count slip shows up on `src_out`, `dst_out` and `cnt_out` at the next `done`. A loop-exit error changes both the cycle at which `done` arrives and the final count. The cycle count is checked to the exact cycle, so an extra or missing wait state in the read or write path is caught on the first operation.

// File: rtl/kce_pkg.sv
package kce_pkg;
  typedef enum logic [1:0] {
    KM_UP   = 2'd0,
    KM_DOWN = 2'd1,
    KM_ROW  = 2'd2,
    KM_UP2  = 2'd3
  } kce_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_TEST  = 2'd2,
    ST_WRITE = 2'd3
  } kce_state_e;
endpackage

// File: rtl/kce_addr_gen.sv
module kce_addr_gen
  import kce_pkg::*;
#(
  parameter int AW      = 16,
  parameter int ROW_LG2 = 3
) (
  input  kce_mode_e         mode,
  input  logic [AW-1:0]     src,
  input  logic [AW-1:0]     dst,
  output logic [AW-1:0]     rd_addr
);
  generate
    if (ROW_LG2 > 0) begin : g_row
      always_comb begin
        if (mode == KM_ROW) rd_addr = {src[AW-1:ROW_LG2], dst[ROW_LG2-1:0]};
        else                rd_addr = src;
      end
    end else begin : g_flat
      logic [AW-1:0] unused_dst;
      assign unused_dst = dst;
      always_comb rd_addr = src;
    end
  endgenerate
endmodule

// File: rtl/kce_step_calc.sv
module kce_step_calc
  import kce_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  kce_mode_e       mode,
  input  logic [AW-1:0]   src,
  input  logic [AW-1:0]   dst,
  input  logic [CW-1:0]   cnt,
  output logic [AW-1:0]   src_nx,
  output logic [AW-1:0]   dst_nx,
  output logic [CW-1:0]   cnt_nx,
  output logic            last
);
  localparam logic [AW-1:0] ONE_A = AW'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  always_comb begin
    unique case (mode)
      KM_DOWN: src_nx = src - ONE_A;
      KM_ROW:  src_nx = src;
      default: src_nx = src + ONE_A;
    endcase
    dst_nx = dst + ONE_A;
    cnt_nx = cnt - ONE_C;
    last   = (cnt_nx == '0);
  end
endmodule

// File: rtl/keyed_copy_engine.sv
module keyed_copy_engine
  import kce_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int CW      = 16,
  parameter int ROW_LG2 = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          repeat_en,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  input  logic [DW-1:0] key_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_out,
  output logic [AW-1:0] dst_out,
  output logic [CW-1:0] cnt_out
);
  kce_state_e    state_q;
  kce_mode_e     mode_q;
  logic          rep_q;
  logic [DW-1:0] key_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;

  logic [AW-1:0] src_nx, dst_nx;
  logic [CW-1:0] cnt_nx;
  logic          last;
  logic          idle;
  logic          step_end;
  logic          hit_key;

  kce_mode_e     ag_mode;
  logic [AW-1:0] ag_src, ag_dst, ag_addr;

  assign idle     = (state_q == ST_IDLE);
  assign hit_key  = (mem_rdata == key_q);
  assign step_end = ((state_q == ST_TEST) && hit_key) || (state_q == ST_WRITE);

  // one address generator serves both the first read and the loop reads
  assign ag_mode = idle ? kce_mode_e'(mode) : mode_q;
  assign ag_src  = idle ? src_in : src_nx;
  assign ag_dst  = idle ? dst_in : dst_nx;

  kce_addr_gen #(.AW(AW), .ROW_LG2(ROW_LG2)) u_addr (
    .mode    (ag_mode),
    .src     (ag_src),
    .dst     (ag_dst),
    .rd_addr (ag_addr)
  );

  kce_step_calc #(.AW(AW), .CW(CW)) u_step (
    .mode   (mode_q),
    .src    (src_q),
    .dst    (dst_q),
    .cnt    (cnt_q),
    .src_nx (src_nx),
    .dst_nx (dst_nx),
    .cnt_nx (cnt_nx),
    .last   (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mode_q    <= KM_UP;
      rep_q     <= 1'b0;
      key_q     <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_q   <= kce_mode_e'(mode);
            rep_q    <= repeat_en;
            key_q    <= key_in;
            src_q    <= src_in;
            dst_q    <= dst_in;
            cnt_q    <= cnt_in;
            mem_addr <= ag_addr;
            mem_rd   <= 1'b1;
            state_q  <= ST_READ;
          end
        end
        ST_READ: state_q <= ST_TEST;
        ST_TEST: begin
          if (!hit_key) begin
            mem_addr  <= dst_q;
            mem_wdata <= mem_rdata;
            mem_wr    <= 1'b1;
            state_q   <= ST_WRITE;
          end
        end
        default: ;
      endcase
      if (step_end) begin
        src_q <= src_nx;
        dst_q <= dst_nx;
        cnt_q <= cnt_nx;
        if (rep_q && !last) begin
          mem_addr <= ag_addr;
          mem_rd   <= 1'b1;
          state_q  <= ST_READ;
        end else begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
      end
    end
  end

  assign busy    = !idle;
  assign src_out = src_q;
  assign dst_out = dst_q;
  assign cnt_out = cnt_q;

  // ---------------- assertions ----------------
  assert_key_not_written_R1: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_wdata != key_q));

  assert_dst_advances_R2: assert property (@(posedge clk) disable iff (rst)
    step_end |=> (dst_q == $past(dst_q) + 1'b1) && (cnt_q == $past(cnt_q) - 1'b1));

  assert_src_down_R3: assert property (@(posedge clk) disable iff (rst)
    (step_end && mode_q == KM_DOWN) |=> (src_q == $past(src_q) - 1'b1));

  assert_row_src_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (step_end && mode_q == KM_ROW) |=> $stable(src_q));

  generate
    if (ROW_LG2 > 0) begin : g_row_chk
      assert_row_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mode_q == KM_ROW) |->
          (mem_addr[ROW_LG2-1:0] == dst_q[ROW_LG2-1:0]) &&
          (mem_addr[AW-1:ROW_LG2] == src_q[AW-1:ROW_LG2]));
    end
  endgenerate

  assert_single_step_R5: assert property (@(posedge clk) disable iff (rst)
    (step_end && !rep_q) |=> done);

  assert_loop_exit_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!rep_q || cnt_q == '0));

  assert_rw_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_read_latency_R7: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (state_q == ST_TEST));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(key_q) && $stable(mode_q) && $stable(rep_q)));
endmodule

// File: tb/keyed_copy_engine_tb.sv
module keyed_copy_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 12;
  localparam int MSZ = 1 << MW;

  logic        clk, rst, start, repeat_en;
  logic [1:0]  mode;
  logic [15:0] src_in, dst_in, cnt_in;
  logic [7:0]  key_in;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, done;
  logic [15:0] src_out, dst_out, cnt_out;

  int checks = 0;
  int errors = 0;

  logic [7:0]    mem  [0:MSZ-1];
  logic [7:0]    refm [0:MSZ-1];
  logic          ld_en;
  logic [MW-1:0] ld_a;
  logic [7:0]    ld_d;

  keyed_copy_engine u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .repeat_en(repeat_en),
    .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .key_in(key_in),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done),
    .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: address aliased to MW bits, one-cycle read latency
  always @(posedge clk) begin
    if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_wr) mem[mem_addr[MW-1:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[MW-1:0]];
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_all(input logic flat, input logic [7:0] val);
    @(negedge clk);
    ld_en = 1'b1;
    for (int i = 0; i < MSZ; i++) begin
      logic [7:0] b;
      if (flat) b = val;
      else if (i % 5 == 0) b = 8'h5A;
      else b = 8'((i * 29) + (i >> 3) + 7);
      ld_a = MW'(i);
      ld_d = b;
      refm[i] = b;
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] m, input logic rep, input logic [15:0] s0,
                        input logic [15:0] d0, input logic [15:0] c0,
                        input logic [7:0] key, input logic poke, input string ptag);
    logic [15:0] s, d, c, a;
    logic [7:0]  b;
    int cyc, n, mism;
    logic busy_ok;
    s = s0; d = d0; c = c0; cyc = 0;
    do begin
      a = (m == 2'd2) ? {s[15:3], d[2:0]} : s;
      b = refm[a[MW-1:0]];
      if (b != key) begin refm[d[MW-1:0]] = b; cyc += 3; end
      else cyc += 2;
      d = d + 16'd1;
      if (m == 2'd1) s = s - 16'd1;
      else if (m != 2'd2) s = s + 16'd1;
      c = c - 16'd1;
    end while (rep && c != 16'd0);

    @(negedge clk);
    start = 1'b1; mode = m; repeat_en = rep;
    src_in = s0; dst_in = d0; cnt_in = c0; key_in = key;
    @(negedge clk);
    start = 1'b0;
    n = 0; busy_ok = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      start = 1'b0;
      if (done) break;
      if (!busy) busy_ok = 1'b0;
      if (poke && n == 2 && cyc >= 5) begin
        start = 1'b1; mode = ~m; repeat_en = ~rep;
        src_in = ~s0; dst_in = ~d0; cnt_in = 16'd1; key_in = ~key;
      end
      if (n > cyc + 10) begin
        check(1'b0, "R7 watchdog", 32'(n), 32'(cyc));
        break;
      end
    end
    check(n == cyc, "R7 cycles", 32'(n), 32'(cyc));
    check(src_out == s, {ptag, " src"}, 32'(src_out), 32'(s));
    check(dst_out == d, {ptag, " dst"}, 32'(dst_out), 32'(d));
    check(cnt_out == c, rep ? "R6 count" : "R5 count", 32'(cnt_out), 32'(c));
    check(busy_ok, "R8 busy", 32'(busy_ok), 32'd1);
    @(negedge clk);
    check(!done && !busy, "R8 done pulse", {30'd0, done, busy}, 32'd0);
    mism = 0;
    for (int i = 0; i < MSZ; i++) if (mem[i] !== refm[i]) mism++;
    check(mism == 0, "R1 memory", 32'(mism), 32'd0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; mode = 2'd0; repeat_en = 1'b0;
    src_in = '0; dst_in = '0; cnt_in = '0; key_in = '0;
    ld_en = 1'b0; ld_a = '0; ld_d = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check({busy, done, mem_rd, mem_wr} == 4'b0, "R10 flags", 32'({busy, done, mem_rd, mem_wr}), 32'd0);
    check(src_out == 0 && dst_out == 0 && cnt_out == 0 && mem_addr == 0 && mem_wdata == 0,
          "R10 values", 32'(src_out | dst_out | cnt_out), 32'd0);

    load_all(1'b0, 8'h00);

    // sweep over modes, repeat flag and counts
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 2; r++) begin
        for (int k = 0; k < 5; k++) begin
          int cn;
          string tg;
          cn = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 3 : (k == 3) ? 7 : 12;
          tg = (m == 1) ? "R3" : (m == 2) ? "R4" : "R2";
          run_op(2'(m), r[0], 16'(16'h0100 + m * 16'h40 + cn),
                 16'(16'h0800 + m * 16'h80 + cn * 3), 16'(cn), 8'h5A, cn == 7, tg);
        end
      end
    end

    // R5: single step with zero count
    run_op(2'd0, 1'b0, 16'h0311, 16'h0911, 16'h0000, 8'h5A, 1'b0, "R5");
    // R9: wrap in both directions
    run_op(2'd1, 1'b1, 16'h0002, 16'hFFFD, 16'd6, 8'h5A, 1'b0, "R9");
    run_op(2'd0, 1'b1, 16'hFFFE, 16'h0A00, 16'd4, 8'h5A, 1'b0, "R9");
    // R4: pattern row with unaligned destination
    run_op(2'd2, 1'b1, 16'h0333, 16'h0205, 16'd12, 8'h5A, 1'b1, "R4");
    // R1: overlapping upward copy replicates sequentially
    run_op(2'd0, 1'b1, 16'h0400, 16'h0401, 16'd8, 8'h11, 1'b0, "R2");
    // R1: skip value that never matches
    run_op(2'd3, 1'b1, 16'h0500, 16'h0C00, 16'd9, 8'hFF, 1'b0, "R2");

    // R6: zero count in repeat mode makes 65536 all-skipped steps
    load_all(1'b1, 8'h5A);
    run_op(2'd0, 1'b1, 16'h1234, 16'h4321, 16'h0000, 8'h5A, 1'b0, "R6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule